// File: doc/BRIEF.md
# Accumulator Machine Instruction Decoder

This block is the decode and operand-address stage of a single-accumulator processor whose data words and instructions are both 12 bits wide. It accepts one fetched instruction together with the program counter of that instruction. It sorts the instruction into one of three classes: memory reference, I/O transfer or register operation. It then presents the fields that the execute stage needs.

For memory reference instructions the block forms the operand address. The address lies either on page zero or on the page that holds the current PC. When the instruction asks for indirection, the block makes exactly one read through its memory port and uses the returned word as the final address. The result is offered on an output stream.

Both the instruction input and the decoded output are valid/ready streams. An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. A result leaves on a clock edge where `out_valid` and `out_ready` are both high. The block holds one instruction at a time, so `in_ready` stays low from acceptance until that instruction's result has been taken.

While `out_valid` is high and `out_ready` is low, every output field holds its value. The memory read request behaves the same way: once raised, it holds its address until `mem_req_ready` is seen. The read data comes back later as a single-cycle `mem_rsp_valid` pulse.

Top module: `acc_insn_decode`

## Requirements
- R1: The opcode is bits 11:9. Opcodes 0 to 5 give class 0 (memory), opcode 6 gives class 1 (I/O) and opcode 7 gives class 2 (register) on `out_class`, and `out_opcode` carries the opcode.
- R2: For a memory instruction with bit 7 (page select) clear, the formed address is the offset in bits 6:0, zero-extended to 12 bits.
- R3: For a memory instruction with bit 7 set, the formed address is PC bits 11:7 joined above the offset in bits 6:0.
- R4: For a memory instruction with bit 8 (indirect) set, exactly one memory read is issued, at the formed address. `out_addr` is then the 12-bit word returned on `mem_rsp_data`. When bit 8 is clear, `out_addr` is the formed address.
- R5: For an I/O instruction, `out_dev` is bits 8:3 and `out_cmd` is bits 2:0. `out_addr` is zero for every class other than memory, and `out_dev` and `out_cmd` are zero for every class other than I/O.
- R6: For a register instruction, `out_micro` is bits 8:0. For the other classes it is zero.
- R7: `in_ready` is high only when no instruction is held. While `out_valid` is high and `out_ready` is low, `out_valid` and all output fields stay unchanged.
- R8: `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready` is high. No read is issued for I/O or register instructions, even when bit 8 is set.
- R9: After reset, `out_valid` and `mem_req_valid` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Decoder can take an instruction |
| in_insn | input | 12 | Fetched instruction word |
| in_pc | input | 12 | Address of the fetched instruction |
| mem_req_valid | output | 1 | Indirect read request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 12 | Address of the indirect read |
| mem_rsp_valid | input | 1 | Read data pulse |
| mem_rsp_data | input | 12 | Word returned by the read |
| out_valid | output | 1 | Decoded result offered |
| out_ready | input | 1 | Execute stage takes the result |
| out_class | output | 2 | 0 memory, 1 I/O, 2 register |
| out_opcode | output | 3 | Opcode field |
| out_addr | output | 12 | Final operand address |
| out_dev | output | 6 | I/O device number |
| out_cmd | output | 3 | I/O command |
| out_micro | output | 9 | Register micro-operation bits |

## Verification
The bench builds the block with its default parameters: 12-bit words, a 3-bit opcode and a 7-bit page offset. With these values, a PC with ones across its upper bits places the current page at the top of memory, which tests the address join at full width.

The memory model returns the formed address XOR 0x5A3. Each indirect result can therefore be told apart from the direct address. The model also delays both the request acceptance and the response, which covers the hold rules on the request and the output. An I/O word with bit 8 set checks that the indirect bit is ignored outside the memory class.

// File: rtl/acc_dec_pkg.sv
package acc_dec_pkg;
  typedef enum logic [1:0] {
    CLS_MEM = 2'd0,
    CLS_IO  = 2'd1,
    CLS_REG = 2'd2
  } op_class_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_OUT  = 2'd3
  } dec_state_e;
endpackage

// File: rtl/acc_field_split.sv
module acc_field_split
  import acc_dec_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int OPC_W  = 3,
  parameter int OFS_W  = 7
) (
  input  logic [WORD_W-1:0] insn,
  output logic [OPC_W-1:0]  opcode,
  output op_class_e         cls,
  output logic              ind_bit
);
  localparam logic [OPC_W-1:0] OPC_REG = {OPC_W{1'b1}};
  localparam logic [OPC_W-1:0] OPC_IO  = OPC_REG - 1'b1;
  localparam int IND_POS = OFS_W + 1;

  assign opcode  = insn[WORD_W-1 -: OPC_W];
  assign ind_bit = insn[IND_POS];

  always_comb begin
    if (opcode == OPC_REG)     cls = CLS_REG;
    else if (opcode == OPC_IO) cls = CLS_IO;
    else                       cls = CLS_MEM;
  end
endmodule

// File: rtl/acc_addr_form.sv
module acc_addr_form #(
  parameter int WORD_W = 12,
  parameter int OFS_W  = 7
) (
  input  logic [WORD_W-1:0] insn,
  input  logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] ea
);
  localparam int PAGE_W = WORD_W - OFS_W;
  localparam int PG_POS = OFS_W;

  logic [PAGE_W-1:0] page_sel;

  generate
    if (PAGE_W > 0) begin : g_paged
      assign page_sel = insn[PG_POS] ? pc[WORD_W-1:OFS_W] : '0;
    end else begin : g_flat
      assign page_sel = '0;
    end
  endgenerate

  assign ea = {page_sel, insn[OFS_W-1:0]};
endmodule

// File: rtl/acc_dec_ctrl.sv
module acc_dec_ctrl
  import acc_dec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic need_ind,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic mem_req_valid,
  output logic out_valid,
  output logic take,
  output logic load_rsp
);
  dec_state_e state_q, state_d;

  assign in_ready      = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign out_valid     = (state_q == ST_OUT);
  assign take          = in_ready && in_valid;
  assign load_rsp      = (state_q == ST_WAIT) && mem_rsp_valid;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (in_valid) state_d = need_ind ? ST_REQ : ST_OUT;
      ST_REQ:  if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) state_d = ST_OUT;
      ST_OUT:  if (out_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/acc_insn_decode.sv
module acc_insn_decode
  import acc_dec_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int OPC_W  = 3,
  parameter int OFS_W  = 7,
  parameter int DEV_W  = 6,
  parameter int CMD_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_insn,
  input  logic [WORD_W-1:0] in_pc,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [WORD_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_class,
  output logic [OPC_W-1:0]  out_opcode,
  output logic [WORD_W-1:0] out_addr,
  output logic [DEV_W-1:0]  out_dev,
  output logic [CMD_W-1:0]  out_cmd,
  output logic [WORD_W-OPC_W-1:0] out_micro
);
  localparam int MICRO_W = WORD_W - OPC_W;

  logic [WORD_W-1:0] insn_q, addr_q, ea_in;
  logic [OPC_W-1:0]  opc_in, opc_q;
  op_class_e         cls_in, cls_q;
  logic              ind_in, ind_q;
  logic              need_ind, take, load_rsp;

  acc_field_split #(.WORD_W(WORD_W), .OPC_W(OPC_W), .OFS_W(OFS_W)) u_split_in (
    .insn(in_insn), .opcode(opc_in), .cls(cls_in), .ind_bit(ind_in)
  );

  acc_field_split #(.WORD_W(WORD_W), .OPC_W(OPC_W), .OFS_W(OFS_W)) u_split_q (
    .insn(insn_q), .opcode(opc_q), .cls(cls_q), .ind_bit(ind_q)
  );

  acc_addr_form #(.WORD_W(WORD_W), .OFS_W(OFS_W)) u_addr (
    .insn(in_insn), .pc(in_pc), .ea(ea_in)
  );

  assign need_ind = (cls_in == CLS_MEM) && ind_in;

  acc_dec_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .need_ind(need_ind),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .out_ready(out_ready), .in_ready(in_ready), .mem_req_valid(mem_req_valid),
    .out_valid(out_valid), .take(take), .load_rsp(load_rsp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insn_q <= '0;
      addr_q <= '0;
    end else if (take) begin
      insn_q <= in_insn;
      addr_q <= ea_in;
    end else if (load_rsp) begin
      addr_q <= mem_rsp_data;
    end
  end

  assign mem_req_addr = addr_q;
  assign out_class    = cls_q;
  assign out_opcode   = opc_q;
  assign out_addr     = (cls_q == CLS_MEM) ? addr_q : '0;
  assign out_dev      = (cls_q == CLS_IO) ? insn_q[DEV_W+CMD_W-1:CMD_W] : '0;
  assign out_cmd      = (cls_q == CLS_IO) ? insn_q[CMD_W-1:0] : '0;
  assign out_micro    = (cls_q == CLS_REG) ? insn_q[MICRO_W-1:0] : '0;

  logic unused_ind;
  assign unused_ind = ind_q;
endmodule

// File: rtl/acc_insn_decode_chk.sv
module acc_insn_decode_chk #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [WORD_W-1:0] mem_req_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_class,
  input logic [WORD_W-1:0] out_addr
);
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_class));

  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && (out_valid || mem_req_valid)));

  p_nonmem_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class != 2'd0 |-> out_addr == '0);

  p_class_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_class != 2'd3);

  p_one_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);
endmodule

bind acc_insn_decode acc_insn_decode_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class),
  .out_addr(out_addr)
);

// File: tb/test_acc_insn_decode.sv
module test_acc_insn_decode;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [11:0] in_insn = '0, in_pc = '0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [11:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [11:0] mem_rsp_data = '0;
  logic out_valid, out_ready = 1'b0;
  logic [1:0] out_class;
  logic [2:0] out_opcode;
  logic [11:0] out_addr;
  logic [5:0] out_dev;
  logic [2:0] out_cmd;
  logic [8:0] out_micro;

  int checks = 0;
  int errors = 0;
  bit reported = 1'b0;

  always #2.5 clk = ~clk;

  acc_insn_decode i_acc_insn_decode (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_pc(in_pc), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class),
    .out_opcode(out_opcode), .out_addr(out_addr), .out_dev(out_dev),
    .out_cmd(out_cmd), .out_micro(out_micro)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] formed(input logic [11:0] insn, input logic [11:0] pc);
    return insn[7] ? {pc[11:7], insn[6:0]} : {5'd0, insn[6:0]};
  endfunction

  task automatic run_insn(input logic [11:0] insn, input logic [11:0] pc, input bit exp_req,
                          input logic [1:0] exp_cls, input logic [11:0] exp_addr,
                          input logic [5:0] exp_dev, input logic [2:0] exp_cmd,
                          input logic [8:0] exp_micro, input string tag);
    logic [11:0] fa;
    fa = formed(insn, pc);
    @(negedge clk);
    in_insn = insn; in_pc = pc; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_insn = '0; in_pc = '0;
    chk(mem_req_valid == exp_req, {tag, " R4/R8 request issued"}, 16'(mem_req_valid), 16'(exp_req));
    if (mem_req_valid) begin
      chk(mem_req_addr == fa, {tag, " R4 read address"}, 16'(mem_req_addr), 16'(fa));
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == fa, {tag, " R8 request held"}, 16'(mem_req_addr), 16'(fa));
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk(!mem_req_valid && !out_valid, {tag, " R4 single read"}, 16'(mem_req_valid), 16'd0);
      @(negedge clk);
      mem_rsp_valid = 1'b1; mem_rsp_data = fa ^ 12'h5A3;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    end
    chk(out_valid == 1'b1, {tag, " out_valid"}, 16'(out_valid), 16'd1);
    chk(out_class == exp_cls && out_opcode == insn[11:9], {tag, " R1 class"}, 16'(out_class), 16'(exp_cls));
    chk(out_addr == exp_addr, {tag, " R2/R3/R4 address"}, 16'(out_addr), 16'(exp_addr));
    chk(out_dev == exp_dev && out_cmd == exp_cmd, {tag, " R5 device/command"},
        16'({out_dev, out_cmd}), 16'({exp_dev, exp_cmd}));
    chk(out_micro == exp_micro, {tag, " R6 micro bits"}, 16'(out_micro), 16'(exp_micro));
    @(negedge clk);
    chk(out_valid && out_addr == exp_addr && !in_ready, {tag, " R7 output held"}, 16'(out_addr), 16'(exp_addr));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, {tag, " R7 released"}, 16'(in_ready), 16'd1);
  endtask

  task automatic t_reset;
    chk(!out_valid && !mem_req_valid && in_ready, "R9 reset state",
        16'({out_valid, mem_req_valid, in_ready}), 16'b001);
  endtask

  task automatic t_page_zero;
    run_insn(12'h07F, 12'hFFF, 1'b0, 2'd0, 12'h07F, '0, '0, '0, "R2 page zero");
    run_insn(12'h400, 12'h123, 1'b0, 2'd0, 12'h000, '0, '0, '0, "R2 opcode 2 offset 0");
  endtask

  task automatic t_cur_page;
    run_insn(12'h2D5, 12'h3A7, 1'b0, 2'd0, 12'h3D5, '0, '0, '0, "R3 current page");
    run_insn(12'hAFF, 12'hF80, 1'b0, 2'd0, 12'hFFF, '0, '0, '0, "R3 top page");
  endtask

  task automatic t_indirect;
    run_insn(12'hB92, 12'h800, 1'b1, 2'd0, 12'h812 ^ 12'h5A3, '0, '0, '0, "R4 indirect current page");
    run_insn(12'h130, 12'h9AB, 1'b1, 2'd0, 12'h030 ^ 12'h5A3, '0, '0, '0, "R4 indirect page zero");
  endtask

  task automatic t_io;
    run_insn(12'hDFF, 12'h456, 1'b0, 2'd1, 12'h000, 6'h3F, 3'h7, '0, "R5 R8 io bit8 set");
    run_insn(12'hC2D, 12'h000, 1'b0, 2'd1, 12'h000, 6'h05, 3'h5, '0, "R5 io");
  endtask

  task automatic t_reg;
    run_insn(12'hF8A, 12'h777, 1'b0, 2'd2, 12'h000, '0, '0, 9'h18A, "R6 register op");
  endtask

  task automatic t_all_opcodes;
    for (int op = 0; op < 6; op++)
      run_insn({3'(op), 9'h0C1}, 12'hE00, 1'b0, 2'd0, 12'hE41, '0, '0, '0, "R1 memory opcode sweep");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!reported) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      reported = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page_zero();
    t_cur_page();
    t_indirect();
    t_io();
    t_reg();
    t_all_opcodes();
    if (!reported) begin
      reported = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule